// File: doc/BRIEF.md
# Vector Lane Compare Unit with Condition Summary

This block compares two 128-bit vector operands lane by lane and produces a 128-bit mask. A lane where the comparison holds comes out all ones, and a lane where it fails comes out all zeros. The integer compares split the vector into bytes, halfwords or words. Equality works on all three widths. Greater-than works on all three widths, in both signed and unsigned forms. The float compares treat the vector as four single-precision lanes and offer equal, greater-than, greater-or-equal and a bounds check. The bounds check writes a two-bit code into the top of each lane instead of a full mask.

When the record flag is set alongside an operation, the block also writes a 4-bit condition summary for the whole vector. The summary states whether every lane came out true, whether no lane did, or whether the result was mixed. For the bounds check it states only whether every lane lies within bounds. The mask and the summary appear one clock after the operands are presented. A new operation can be issued on every cycle.

Top module: `vcmp_unit`

## Requirements
- R1: `opSel` selects the operation. Codes 0, 1 and 2 test for equality on 8-bit, 16-bit and 32-bit lanes (16, 8 or 4 lanes). Codes 3, 4 and 5 test unsigned greater-than on those widths, and codes 6, 7 and 8 test signed greater-than. Code 9 tests float equality, code 10 float greater-or-equal, code 11 float greater-than, and code 12 is the float bounds check. Float operations use four 32-bit lanes, with lane i in bits [32i+31:32i].
- R2: Every bit of a lane is 1 when the lane's comparison holds and 0 when it fails. This applies to every operation except the bounds check.
- R3: Signed greater-than reads each lane as two's complement and unsigned greater-than reads it as a plain binary number. For example, byte 0x80 > 0x01 holds unsigned but fails signed.
- R4: Each recorded operation other than the bounds check writes a summary. The summary is 8 when every lane is true, 2 when no lane is true, and 0 otherwise.
- R5: For the bounds check, bit 31 of a lane is 1 when a <= b is false, and bit 30 is 1 when a >= -b is false. The value -b is b with its sign bit inverted. Bits 29:0 of each lane are 0.
- R6: A recorded bounds check writes summary 2 when the whole mask is zero and 0 otherwise.
- R7: A float comparison with a NaN in either lane operand is false. A NaN lane in the bounds check therefore sets both bit 31 and bit 30.
- R8: Float comparisons treat +0 and -0 as equal. Infinities and finite values follow their numeric order.
- R9: `summaryValid` is high in the cycle after an operation issued with `recordEn` = 1 and low otherwise. `summaryOut` holds its value while no recorded operation completes.
- R10: Codes 13 to 15 give an all-zero mask. When recorded, they give summary 2.
- R11: The mask and summary appear one clock after the inputs. After reset, `maskOut`, `summaryOut` and `summaryValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 4 | Operation code (R1) |
| recordEn | input | 1 | Write the condition summary for this operation |
| srcA | input | 128 | First operand |
| srcB | input | 128 | Second operand |
| maskOut | output | 128 | Registered per-lane result |
| summaryOut | output | 4 | Registered condition summary |
| summaryValid | output | 1 | A summary was written in the previous cycle |

## Verification
The hardest outcome to reach from the ports is an all-true summary, or any case that hinges on equal lanes or signed zeros. Random 128-bit operands almost never give equal lanes, so the bench builds the second operand from the first. It copies, nudges or replaces each byte, and draws float lanes from a small pool that mixes zeros of both signs, NaN, infinities and ordinary values. Directed steps then force the summary corners: all lanes equal, no lanes equal, every lane in bounds, a NaN lane in the bounds check, and the signed and unsigned readings of the same bytes.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  typedef enum logic [3:0] {
    OP_EQ_B  = 4'd0,
    OP_EQ_H  = 4'd1,
    OP_EQ_W  = 4'd2,
    OP_GTU_B = 4'd3,
    OP_GTU_H = 4'd4,
    OP_GTU_W = 4'd5,
    OP_GTS_B = 4'd6,
    OP_GTS_H = 4'd7,
    OP_GTS_W = 4'd8,
    OP_EQ_F  = 4'd9,
    OP_GE_F  = 4'd10,
    OP_GT_F  = 4'd11,
    OP_BND_F = 4'd12
  } opcode_e;

  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W} laneSz_e;
  typedef enum logic [1:0] {K_EQ, K_GT, K_GE, K_BND} cmpKind_e;

  typedef struct packed {
    laneSz_e  laneSz;
    cmpKind_e kind;
    logic     isSigned;
    logic     isFloat;
    logic     isNull;
    logic     recordUpd;
  } ctrlStrobes_t;

  localparam logic [3:0] SUM_ALL   = 4'h8;
  localparam logic [3:0] SUM_NONE  = 4'h2;
  localparam logic [3:0] SUM_MIXED = 4'h0;

endpackage

// File: rtl/vcmp_int_lanes.sv
module vcmp_int_lanes #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8,
  localparam int NL    = VEC_W / LANE_W
) (
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic [NL-1:0]    eqV,
  output logic [NL-1:0]    gtuV,
  output logic [NL-1:0]    gtsV
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = srcA[i*LANE_W +: LANE_W];
    assign lb = srcB[i*LANE_W +: LANE_W];
    assign eqV[i]  = (la == lb);
    assign gtuV[i] = (la > lb);
    assign gtsV[i] = ($signed(la) > $signed(lb));
  end
endmodule

// File: rtl/vcmp_fp_lane.sv
module vcmp_fp_lane #(
  parameter int FW = 32,
  localparam int EW = 8,
  localparam int MW = FW - EW - 1
) (
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  output logic          eqO,
  output logic          gtO,
  output logic          geO,
  output logic          leO,
  output logic          geNegO
);
  logic [FW-1:0] negB;
  logic nanA, nanB, zeroA, zeroB, anyNan;
  logic [FW-1:0] keyA, keyB, keyNegB;

  function automatic logic [FW-1:0] orderKey(input logic [FW-1:0] x);
    if (x[FW-2:0] == '0)  return {1'b1, {(FW-1){1'b0}}};
    else if (x[FW-1])     return ~x;
    else                  return {1'b1, x[FW-2:0]};
  endfunction

  assign negB   = {~b[FW-1], b[FW-2:0]};
  assign nanA   = (&a[FW-2 -: EW]) && (|a[MW-1:0]);
  assign nanB   = (&b[FW-2 -: EW]) && (|b[MW-1:0]);
  assign zeroA  = (a[FW-2:0] == '0);
  assign zeroB  = (b[FW-2:0] == '0);
  assign anyNan = nanA | nanB;

  assign keyA    = orderKey(a);
  assign keyB    = orderKey(b);
  assign keyNegB = orderKey(negB);

  assign eqO    = !anyNan && (keyA == keyB);
  assign gtO    = !anyNan && (keyA >  keyB);
  assign geO    = !anyNan && (keyA >= keyB);
  assign leO    = !anyNan && (keyA <= keyB);
  assign geNegO = !anyNan && (keyA >= keyNegB);

  always_comb begin
    if (anyNan) begin
      p_nan_false_r7: assert (!eqO && !gtO && !geO && !leO && !geNegO)
        else $error("NaN operand produced a true float compare");
    end
    if (zeroA && zeroB && !anyNan) begin
      p_zero_equal_r8: assert (eqO && leO && geO && geNegO)
        else $error("signed zeros did not compare equal");
    end
  end
endmodule

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   opSel,
  input  logic         recordEn,
  output ctrlStrobes_t strb,
  output logic         summaryValid
);
  always_comb begin
    strb           = '0;
    strb.recordUpd = recordEn;
    unique case (opSel)
      OP_EQ_B:  begin strb.laneSz = SZ_B; strb.kind = K_EQ; end
      OP_EQ_H:  begin strb.laneSz = SZ_H; strb.kind = K_EQ; end
      OP_EQ_W:  begin strb.laneSz = SZ_W; strb.kind = K_EQ; end
      OP_GTU_B: begin strb.laneSz = SZ_B; strb.kind = K_GT; end
      OP_GTU_H: begin strb.laneSz = SZ_H; strb.kind = K_GT; end
      OP_GTU_W: begin strb.laneSz = SZ_W; strb.kind = K_GT; end
      OP_GTS_B: begin strb.laneSz = SZ_B; strb.kind = K_GT; strb.isSigned = 1'b1; end
      OP_GTS_H: begin strb.laneSz = SZ_H; strb.kind = K_GT; strb.isSigned = 1'b1; end
      OP_GTS_W: begin strb.laneSz = SZ_W; strb.kind = K_GT; strb.isSigned = 1'b1; end
      OP_EQ_F:  begin strb.laneSz = SZ_W; strb.kind = K_EQ;  strb.isFloat = 1'b1; end
      OP_GE_F:  begin strb.laneSz = SZ_W; strb.kind = K_GE;  strb.isFloat = 1'b1; end
      OP_GT_F:  begin strb.laneSz = SZ_W; strb.kind = K_GT;  strb.isFloat = 1'b1; end
      OP_BND_F: begin strb.laneSz = SZ_W; strb.kind = K_BND; strb.isFloat = 1'b1; end
      default:  strb.isNull = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) summaryValid <= 1'b0;
    else       summaryValid <= recordEn;
  end
endmodule

// File: rtl/vcmp_datapath.sv
module vcmp_datapath
  import vcmp_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int NB = VEC_W / 8,
  localparam int NH = VEC_W / 16,
  localparam int NW = VEC_W / 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic [VEC_W-1:0] maskQ,
  output logic [3:0]       sumQ
);
  logic [NB-1:0] eqB, gtuB, gtsB, hitB;
  logic [NH-1:0] eqH, gtuH, gtsH, hitH;
  logic [NW-1:0] eqW, gtuW, gtsW, hitW;
  logic [NW-1:0] fEq, fGt, fGe, fLe, fGeNeg, hitF;
  logic [VEC_W-1:0] expB, expH, expW, expF, bndMask, maskD;
  logic [3:0] sumD;
  logic boundQ, nullQ;

  vcmp_int_lanes #(.VEC_W(VEC_W), .LANE_W(8)) u_lanesB (
    .srcA(srcA), .srcB(srcB), .eqV(eqB), .gtuV(gtuB), .gtsV(gtsB));
  vcmp_int_lanes #(.VEC_W(VEC_W), .LANE_W(16)) u_lanesH (
    .srcA(srcA), .srcB(srcB), .eqV(eqH), .gtuV(gtuH), .gtsV(gtsH));
  vcmp_int_lanes #(.VEC_W(VEC_W), .LANE_W(32)) u_lanesW (
    .srcA(srcA), .srcB(srcB), .eqV(eqW), .gtuV(gtuW), .gtsV(gtsW));

  for (genvar w = 0; w < NW; w++) begin : g_fp
    vcmp_fp_lane #(.FW(32)) u_fp (
      .a(srcA[w*32 +: 32]), .b(srcB[w*32 +: 32]),
      .eqO(fEq[w]), .gtO(fGt[w]), .geO(fGe[w]), .leO(fLe[w]), .geNegO(fGeNeg[w]));
    assign bndMask[w*32 +: 32] = {~fLe[w], ~fGeNeg[w], 30'b0};
    assign expW[w*32 +: 32]    = {32{hitW[w]}};
    assign expF[w*32 +: 32]    = {32{hitF[w]}};
  end

  for (genvar i = 0; i < NB; i++) begin : g_expB
    assign expB[i*8 +: 8] = {8{hitB[i]}};
  end
  for (genvar i = 0; i < NH; i++) begin : g_expH
    assign expH[i*16 +: 16] = {16{hitH[i]}};
  end

  always_comb begin
    if (strb.kind == K_EQ) begin
      hitB = eqB; hitH = eqH; hitW = eqW;
    end else if (strb.isSigned) begin
      hitB = gtsB; hitH = gtsH; hitW = gtsW;
    end else begin
      hitB = gtuB; hitH = gtuH; hitW = gtuW;
    end
    unique case (strb.kind)
      K_EQ:    hitF = fEq;
      K_GT:    hitF = fGt;
      default: hitF = fGe;
    endcase
  end

  always_comb begin
    if (strb.isNull)               maskD = '0;
    else if (strb.kind == K_BND)   maskD = bndMask;
    else if (strb.isFloat)         maskD = expF;
    else begin
      unique case (strb.laneSz)
        SZ_B:    maskD = expB;
        SZ_H:    maskD = expH;
        default: maskD = expW;
      endcase
    end
  end

  always_comb begin
    if (maskD == '0)                            sumD = SUM_NONE;
    else if (strb.kind != K_BND && (&maskD))    sumD = SUM_ALL;
    else                                        sumD = SUM_MIXED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      sumQ   <= SUM_MIXED;
      boundQ <= 1'b0;
      nullQ  <= 1'b0;
    end else begin
      maskQ  <= maskD;
      boundQ <= (strb.kind == K_BND) && !strb.isNull;
      nullQ  <= strb.isNull;
      if (strb.recordUpd) sumQ <= sumD;
    end
  end

  function automatic logic bytesUniform(input logic [VEC_W-1:0] m);
    for (int i = 0; i < NB; i++)
      if (m[i*8 +: 8] != 8'h00 && m[i*8 +: 8] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic boundLowClear(input logic [VEC_W-1:0] m);
    for (int w = 0; w < NW; w++)
      if (m[w*32 +: 30] != '0) return 1'b0;
    return 1'b1;
  endfunction

  p_lane_uniform_r2: assert property (@(posedge clk) disable iff (!rstN)
    !boundQ |-> bytesUniform(maskQ))
    else $error("non-bounds result lane is not all ones or all zeros");

  p_bound_low_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    boundQ |-> boundLowClear(maskQ))
    else $error("bounds result has bits below 30 set");

  p_null_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    nullQ |-> (maskQ == '0))
    else $error("reserved opcode produced a nonzero mask");
endmodule

// File: rtl/vcmp_unit.sv
module vcmp_unit
  import vcmp_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       opSel,
  input  logic             recordEn,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic [VEC_W-1:0] maskOut,
  output logic [3:0]       summaryOut,
  output logic             summaryValid
);
  ctrlStrobes_t strb;

  vcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opSel(opSel), .recordEn(recordEn),
    .strb(strb), .summaryValid(summaryValid));

  vcmp_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcA(srcA), .srcB(srcB),
    .maskQ(maskOut), .sumQ(summaryOut));

  p_summary_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !summaryValid |-> $stable(summaryOut))
    else $error("summary changed without a recorded operation");

  p_summary_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    summaryValid |-> (summaryOut == SUM_ALL || summaryOut == SUM_NONE || summaryOut == SUM_MIXED))
    else $error("summary holds an undefined code");

  p_all_true_r4: assert property (@(posedge clk) disable iff (!rstN)
    (summaryValid && summaryOut == SUM_ALL) |-> (&maskOut))
    else $error("all-true summary with a false lane");

  p_none_true_r6: assert property (@(posedge clk) disable iff (!rstN)
    (summaryValid && summaryOut == SUM_NONE) |-> (maskOut == '0))
    else $error("none-true summary with a nonzero mask");
endmodule

// File: tb/vcmp_unit_tb.sv
`timescale 1ns/1ps
module vcmp_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] opSel = '0;
  logic recordEn = 1'b0;
  logic [127:0] srcA = '0, srcB = '0;
  logic [127:0] maskOut;
  logic [3:0] summaryOut;
  logic summaryValid;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  logic [3:0] expSum = 4'h0;

  always #2 clk = ~clk;

  vcmp_unit u_dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .recordEn(recordEn),
    .srcA(srcA), .srcB(srcB), .maskOut(maskOut),
    .summaryOut(summaryOut), .summaryValid(summaryValid));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit isNan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic real toReal(input logic [31:0] x);
    real m;
    int e;
    e = int'(x[30:23]);
    if (e == 255) m = 1.0e300;
    else if (e == 0) m = real'(x[22:0]) * (2.0 ** (-149));
    else m = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return x[31] ? -m : m;
  endfunction

  function automatic logic [127:0] refMask(input logic [3:0] op,
                                           input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    logic [127:0] ta, tb;
    int w, n;
    longint xa, xb, lm;
    bit hit;
    r = '0;
    if (op <= 4'd8) begin
      w = (op % 3 == 0) ? 8 : (op % 3 == 1) ? 16 : 32;
      n = 128 / w;
      lm = (longint'(1) << w) - 1;
      for (int i = 0; i < n; i++) begin
        ta = a >> (i * w);
        tb = b >> (i * w);
        xa = longint'(ta[31:0]) & lm;
        xb = longint'(tb[31:0]) & lm;
        if (op >= 4'd6) begin
          if (xa >= (longint'(1) << (w - 1))) xa = xa - (longint'(1) << w);
          if (xb >= (longint'(1) << (w - 1))) xb = xb - (longint'(1) << w);
        end
        hit = (op <= 4'd2) ? (xa == xb) : (xa > xb);
        for (int j = 0; j < w; j++) r[i*w + j] = hit;
      end
    end else if (op <= 4'd12) begin
      for (int i = 0; i < 4; i++) begin
        logic [31:0] fa, fb;
        bit nan;
        real ra, rb;
        fa = a[i*32 +: 32];
        fb = b[i*32 +: 32];
        nan = isNan(fa) || isNan(fb);
        ra = toReal(fa);
        rb = toReal(fb);
        if (op == 4'd12) begin
          r[i*32 + 31] = !(!nan && ra <= rb);
          r[i*32 + 30] = !(!nan && ra >= -rb);
        end else begin
          case (op)
            4'd9:    hit = !nan && (ra == rb);
            4'd10:   hit = !nan && (ra >= rb);
            default: hit = !nan && (ra > rb);
          endcase
          for (int j = 0; j < 32; j++) r[i*32 + j] = hit;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] refSum(input logic [3:0] op, input logic [127:0] m);
    if (m == '0) return 4'h2;
    if (op != 4'd12 && m == '1) return 4'h8;
    return 4'h0;
  endfunction

  task automatic step(input logic [3:0] op, input logic [127:0] a, input logic [127:0] b,
                      input logic rec, input string tag);
    logic [127:0] em;
    @(negedge clk);
    opSel = op; srcA = a; srcB = b; recordEn = rec;
    em = refMask(op, a, b);
    if (rec) expSum = refSum(op, em);
    @(posedge clk);
    #1;
    chk(maskOut == em, tag, "mask", maskOut, em);
    chk(summaryOut == expSum, rec ? ((op == 4'd12) ? "R6" : "R4") : "R9",
        "summary", {124'b0, summaryOut}, {124'b0, expSum});
    chk(summaryValid == rec, "R9", "summaryValid", {127'b0, summaryValid}, {127'b0, rec});
  endtask

  function automatic logic [31:0] pickFloat(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h3F80_0000;
      3: return 32'hBF80_0000;
      4: return 32'h4020_0000;
      5: return 32'h7FC0_0000;
      6: return 32'h7F80_0000;
      7: return 32'hFF80_0000;
      8: return 32'h0000_0005;
      default: return {$urandom_range(1, 0) == 1, 8'($urandom_range(200, 60)), 23'($urandom)};
    endcase
  endfunction

  function automatic string tagFor(input logic [3:0] op);
    if (op <= 4'd2) return "R1";
    if (op <= 4'd8) return "R3";
    if (op <= 4'd11) return "R7";
    if (op == 4'd12) return "R5";
    return "R10";
  endfunction

  initial begin
    logic [127:0] a, b;
    repeat (3) @(posedge clk);
    #1;
    chk(maskOut == '0, "R11", "reset mask", maskOut, '0);
    chk(summaryOut == 4'h0, "R11", "reset summary", {124'b0, summaryOut}, '0);
    chk(summaryValid == 1'b0, "R11", "reset valid", {127'b0, summaryValid}, '0);
    @(negedge clk);
    rstN = 1'b1;

    a = {$urandom, $urandom, $urandom, $urandom};
    step(4'd0, a, a, 1'b1, "R2");
    step(4'd2, a, ~a, 1'b1, "R2");
    step(4'd1, {8{16'h1234}}, {4{16'h1234, 16'h0000}}, 1'b1, "R4");
    step(4'd3, {16{8'h80}}, {16{8'h01}}, 1'b1, "R3");
    step(4'd6, {16{8'h80}}, {16{8'h01}}, 1'b1, "R3");
    step(4'd8, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 1'b0, "R3");
    step(4'd5, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 1'b0, "R9");
    step(4'd9, {4{32'h0000_0000}}, {4{32'h8000_0000}}, 1'b1, "R8");
    step(4'd10, {4{32'h8000_0000}}, {4{32'h0000_0000}}, 1'b1, "R8");
    step(4'd11, {32'h7FC0_0000, 32'h3F80_0000, 32'h7F80_0000, 32'h4020_0000},
         {32'h3F80_0000, 32'h7FC0_0000, 32'h3F80_0000, 32'hFF80_0000}, 1'b1, "R7");
    step(4'd12, {32'h3F80_0000, 32'h0000_0000, 32'hBF80_0000, 32'h8000_0000},
         {4{32'h4020_0000}}, 1'b1, "R6");
    step(4'd12, {32'h7FC0_0000, 32'h4040_0000, 32'hC040_0000, 32'h3F80_0000},
         {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000}, 1'b1, "R5");
    step(4'd13, a, a, 1'b1, "R10");
    step(4'd15, a, ~a, 1'b0, "R10");

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] op;
      op = 4'($urandom_range(15, 0));
      if (op >= 4'd9 && op <= 4'd12) begin
        for (int i = 0; i < 4; i++) begin
          a[i*32 +: 32] = pickFloat($urandom_range(12, 0));
          b[i*32 +: 32] = ($urandom_range(3, 0) == 0) ? a[i*32 +: 32]
                                                      : pickFloat($urandom_range(12, 0));
        end
      end else begin
        a = {$urandom, $urandom, $urandom, $urandom};
        b = a;
        for (int i = 0; i < 16; i++) begin
          case ($urandom_range(3, 0))
            0: b[i*8 +: 8] = a[i*8 +: 8] + 8'd1;
            1: b[i*8 +: 8] = 8'($urandom);
            default: ;
          endcase
        end
      end
      step(op, a, b, $urandom_range(9, 0) < 7, tagFor(op));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule